// File: doc/BRIEF.md
# PLL Retune Sequencer

This block steps one PLL through a safe change of its divider settings. A one-cycle start request carries the reference divider, feedback multiplier and output divider as plain values (not minus-one). The sequencer first checks the request against the VCO and output frequency limits. If the request fails, it rejects it without touching anything.

An accepted request runs the same ordered handoff every time. The mode field drops to the slow bypass setting, which runs on the 24 MHz reference. The PLL reset is then raised and the divider fields are written in their minus-one encodings, together with a derived bandwidth field. After a settle time counted in system-clock cycles, the reset is released. The sequencer then polls the lock input and returns the mode to normal once lock arrives.

The caller sees a busy level for the whole run, then a one-cycle done pulse or a one-cycle error pulse. The error pulse means either a rejected request or a lock timeout. The analog PLL itself sits outside the block: the control outputs drive its configuration fields, and its lock status comes back on an input.

Top module: `pll_retune_seq`

## Requirements
- R1: While reset is applied, the mode output is slow (2'b00), the PLL reset output is low, all four divider fields are zero, and busy, done and error are low.
- R2: A start pulse in idle with a valid request sets the mode to slow (2'b00) and raises busy on the next clock edge.
- R3: The PLL reset output rises one cycle after the mode goes slow. The mode is slow whenever the PLL reset output is high.
- R4: One cycle after the PLL reset rises, the fields are loaded with their minus-one encodings. The reference field (6 bits) holds NR-1, the feedback field (13 bits) holds NF-1, the output field (4 bits) holds NO-1, and the bandwidth field (12 bits) holds (NF>>1)-1. The fields change at no other time.
- R5: The PLL reset is released exactly SETTLE_CYC = CLK_HZ/1e6 × SETTLE_US cycles after the fields are written.
- R6: After release, the sequencer acts on the first edge at which lock is high. At that edge the mode becomes normal (2'b01), busy falls and done pulses for one cycle.
- R7: A request whose NO is neither 1 nor an even value from 2 to 16 is rejected. The same holds when NR is 0 or above 64, or NF is 0 or above 8192. A rejection gives an error pulse on the next edge and changes no other output.
- R8: A request is also rejected when the VCO (24 MHz × NF / NR) falls outside 440–2200 MHz, or the output (VCO / NO) falls outside 27.5–2200 MHz. Both bounds are inclusive.
- R9: A start pulse while busy is ignored and leaves the fields and the running sequence unchanged.
- R10: If lock has not been seen after LOCK_TMO_CYC polling edges, the sequencer pulses error and drops busy. The mode stays slow and the PLL reset stays released.
- R11: Done and error are never high together, and busy is low whenever either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to retune |
| nr_i | input | 7 | Reference divider value NR |
| nf_i | input | 14 | Feedback multiplier value NF |
| no_i | input | 5 | Output divider value NO |
| lock_i | input | 1 | PLL lock status |
| mode_o | output | 2 | PLL mode: 00 slow, 01 normal |
| pll_rst_o | output | 1 | PLL reset |
| refdiv_o | output | 6 | Reference divider field (NR-1) |
| fbdiv_o | output | 13 | Feedback divider field (NF-1) |
| outdiv_o | output | 4 | Output divider field (NO-1) |
| bwadj_o | output | 12 | Bandwidth field ((NF>>1)-1) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle reject or timeout pulse |

## Verification
The bench builds the block with CLK_HZ at 2 MHz and SETTLE_US at 10, which makes the settle window 20 cycles. It sets LOCK_TMO_CYC to 40 and keeps the timeout variant enabled. With these values, full sequences, exact settle counts and the lock timeout all fit inside a few hundred cycles per run. The field widths stay at their defaults. This keeps the exact 440 MHz VCO and 27.5 MHz output boundaries reachable, along with the just-out-of-range VCO cases and the odd output divider.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;

   typedef enum logic [1:0] {
      PM_SLOW   = 2'b00,
      PM_NORMAL = 2'b01,
      PM_DEEP   = 2'b10
   } pll_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SLOW,
      ST_PROG,
      ST_SETTLE,
      ST_POLL
   } seq_state_e;

   localparam longint unsigned VCO_MIN_KHZ = 64'd440000;
   localparam longint unsigned VCO_MAX_KHZ = 64'd2200000;
   localparam longint unsigned OUT_MIN_KHZ = 64'd27500;
   localparam longint unsigned OUT_MAX_KHZ = 64'd2200000;

endpackage

// File: rtl/pll_req_check.sv
module pll_req_check
   import pll_retune_pkg::*;
#(
   parameter int unsigned NR_W    = 6,
   parameter int unsigned NF_W    = 13,
   parameter int unsigned NO_W    = 4,
   parameter int unsigned REF_KHZ = 24000
) (
   input  logic [NR_W:0] nr_i,
   input  logic [NF_W:0] nf_i,
   input  logic [NO_W:0] no_i,
   output logic          ok_o
);

   localparam longint unsigned MAX_NR = 64'd1 << NR_W;
   localparam longint unsigned MAX_NF = 64'd1 << NF_W;
   localparam longint unsigned MAX_NO = 64'd1 << NO_W;

   logic [63:0] nr_w, nf_w, no_w;
   logic [63:0] num, den_vco, den_out;
   logic        fmt_ok, no_ok, vco_ok, out_ok;

   always_comb begin
      nr_w    = 64'(nr_i);
      nf_w    = 64'(nf_i);
      no_w    = 64'(no_i);
      num     = 64'(REF_KHZ) * nf_w;
      den_vco = nr_w;
      den_out = nr_w * no_w;
      fmt_ok  = (nr_w != 0) && (nr_w <= MAX_NR) &&
                (nf_w != 0) && (nf_w <= MAX_NF) &&
                (no_w != 0) && (no_w <= MAX_NO);
      no_ok   = (no_w == 64'd1) || !no_i[0];
      vco_ok  = (num >= VCO_MIN_KHZ * den_vco) && (num <= VCO_MAX_KHZ * den_vco);
      out_ok  = (num >= OUT_MIN_KHZ * den_out) && (num <= OUT_MAX_KHZ * den_out);
      ok_o    = fmt_ok && no_ok && vco_ok && out_ok;
   end

endmodule

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic             last_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (dec_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
   import pll_retune_pkg::*;
#(
   parameter int unsigned NR_W        = 6,
   parameter int unsigned NF_W        = 13,
   parameter int unsigned NO_W        = 4,
   parameter int unsigned BW_W        = 12,
   parameter int unsigned REF_KHZ     = 24000,
   parameter int unsigned CLK_HZ      = 100000000,
   parameter int unsigned SETTLE_US   = 10,
   parameter int unsigned LOCK_TMO_CYC = 100000,
   parameter bit          TMO_EN      = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            start_i,
   input  logic [NR_W:0]   nr_i,
   input  logic [NF_W:0]   nf_i,
   input  logic [NO_W:0]   no_i,
   input  logic            lock_i,
   output logic [1:0]      mode_o,
   output logic            pll_rst_o,
   output logic [NR_W-1:0] refdiv_o,
   output logic [NF_W-1:0] fbdiv_o,
   output logic [NO_W-1:0] outdiv_o,
   output logic [BW_W-1:0] bwadj_o,
   output logic            busy_o,
   output logic            done_o,
   output logic            err_o
);

   localparam int unsigned SETTLE_CYC = (CLK_HZ / 1000000) * SETTLE_US;
   localparam int unsigned CNT_MAX    = (SETTLE_CYC > LOCK_TMO_CYC) ? SETTLE_CYC : LOCK_TMO_CYC;
   localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("settle window must be at least one cycle");
   end
   if (BW_W + 1 < NF_W) begin : g_bad_bw
      $error("bandwidth field too narrow for feedback range");
   end
   if (TMO_EN && (LOCK_TMO_CYC < 1)) begin : g_bad_tmo
      $error("lock timeout must be at least one cycle");
   end

   seq_state_e      state_q;
   pll_mode_e       mode_q;
   logic            rst_q, busy_q, done_q, err_q;
   logic [NR_W:0]   nr_l;
   logic [NF_W:0]   nf_l;
   logic [NO_W:0]   no_l;
   logic [NR_W-1:0] ref_q;
   logic [NF_W-1:0] fb_q;
   logic [NO_W-1:0] out_q;
   logic [BW_W-1:0] bw_q;

   logic             req_ok;
   logic             t_load, t_dec, t_last, tmo_hit;
   logic [CNT_W-1:0] t_val;

   pll_req_check #(
      .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .REF_KHZ(REF_KHZ)
   ) u_check (
      .nr_i(nr_i), .nf_i(nf_i), .no_i(no_i), .ok_o(req_ok)
   );

   always_comb begin
      t_load = (state_q == ST_PROG) || ((state_q == ST_SETTLE) && t_last);
      t_val  = (state_q == ST_PROG) ? CNT_W'(SETTLE_CYC) : CNT_W'(LOCK_TMO_CYC);
      t_dec  = (state_q == ST_SETTLE) || (state_q == ST_POLL);
   end

   pll_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(t_load),
      .load_val_i(t_val), .dec_i(t_dec), .last_o(t_last)
   );

   if (TMO_EN) begin : g_tmo
      assign tmo_hit = t_last;
   end else begin : g_no_tmo
      assign tmo_hit = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         mode_q  <= PM_SLOW;
         rst_q   <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         nr_l    <= '0;
         nf_l    <= '0;
         no_l    <= '0;
         ref_q   <= '0;
         fb_q    <= '0;
         out_q   <= '0;
         bw_q    <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (req_ok) begin
                     mode_q  <= PM_SLOW;
                     busy_q  <= 1'b1;
                     nr_l    <= nr_i;
                     nf_l    <= nf_i;
                     no_l    <= no_i;
                     state_q <= ST_SLOW;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            ST_SLOW: begin
               rst_q   <= 1'b1;
               state_q <= ST_PROG;
            end
            ST_PROG: begin
               ref_q   <= NR_W'(nr_l - 1'b1);
               fb_q    <= NF_W'(nf_l - 1'b1);
               out_q   <= NO_W'(no_l - 1'b1);
               bw_q    <= BW_W'((nf_l >> 1) - 1'b1);
               state_q <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (t_last) begin
                  rst_q   <= 1'b0;
                  state_q <= ST_POLL;
               end
            end
            ST_POLL: begin
               if (lock_i) begin
                  mode_q  <= PM_NORMAL;
                  busy_q  <= 1'b0;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (tmo_hit) begin
                  busy_q  <= 1'b0;
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mode_o    = mode_q;
   assign pll_rst_o = rst_q;
   assign refdiv_o  = ref_q;
   assign fbdiv_o   = fb_q;
   assign outdiv_o  = out_q;
   assign bwadj_o   = bw_q;
   assign busy_o    = busy_q;
   assign done_o    = done_q;
   assign err_o     = err_q;

endmodule

// File: rtl/pll_retune_chk.sv
module pll_retune_chk #(
   parameter int unsigned NR_W = 6,
   parameter int unsigned NF_W = 13,
   parameter int unsigned NO_W = 4,
   parameter int unsigned BW_W = 12
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic [1:0]      mode_o,
   input logic            pll_rst_o,
   input logic [NR_W-1:0] refdiv_o,
   input logic [NF_W-1:0] fbdiv_o,
   input logic [NO_W-1:0] outdiv_o,
   input logic [BW_W-1:0] bwadj_o,
   input logic            busy_o,
   input logic            done_o,
   input logic            err_o
);

   // R2
   busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> (mode_o == 2'b00) && !pll_rst_o);

   // R3
   rst_in_slow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pll_rst_o |-> (mode_o == 2'b00));

   // R4
   fields_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((refdiv_o != $past(refdiv_o)) || (fbdiv_o != $past(fbdiv_o)) ||
       (outdiv_o != $past(outdiv_o)) || (bwadj_o != $past(bwadj_o))) |-> pll_rst_o);

   // R5
   release_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pll_rst_o) |-> busy_o);

   // R6
   normal_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_o == 2'b01) && ($past(mode_o) != 2'b01)) |-> done_o);

   // R11
   pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(done_o && err_o));

   // R11
   pulse_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o || err_o) |-> !busy_o);

endmodule

bind pll_retune_seq pll_retune_chk #(
   .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .mode_o(mode_o), .pll_rst_o(pll_rst_o),
   .refdiv_o(refdiv_o), .fbdiv_o(fbdiv_o), .outdiv_o(outdiv_o), .bwadj_o(bwadj_o),
   .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_pll_retune_seq.sv
module tb_pll_retune_seq;

   localparam int SETTLE = 20;
   localparam int TMO    = 40;
   localparam int LOCK_DLY = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [6:0]  nr = '0;
   logic [13:0] nf = '0;
   logic [4:0]  no = '0;
   logic        lock = 1'b0;
   logic [1:0]  mode;
   logic        prst, busy, done, err;
   logic [5:0]  refdiv;
   logic [12:0] fbdiv;
   logic [3:0]  outdiv;
   logic [11:0] bwadj;

   always #5 clk = ~clk;

   pll_retune_seq #(
      .CLK_HZ(2000000), .SETTLE_US(10), .LOCK_TMO_CYC(TMO), .TMO_EN(1'b1)
   ) dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .nr_i(nr), .nf_i(nf), .no_i(no),
      .lock_i(lock), .mode_o(mode), .pll_rst_o(prst), .refdiv_o(refdiv),
      .fbdiv_o(fbdiv), .outdiv_o(outdiv), .bwadj_o(bwadj), .busy_o(busy),
      .done_o(done), .err_o(err)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // behavioural reference model
   int ph, cnt, m_mode, m_ref, m_fb, m_out, m_bw, l_nr, l_nf, l_no;
   bit m_rst, m_busy, m_done, m_err, model_on;

   function automatic bit req_ok(int vnr, int vnf, int vno);
      longint num;
      if (vnr < 1 || vnr > 64 || vnf < 1 || vnf > 8192 || vno < 1 || vno > 16) return 0;
      if (vno != 1 && (vno % 2) != 0) return 0;
      num = 64'(24000) * vnf;
      if (num < 440000 * longint'(vnr) || num > 2200000 * longint'(vnr)) return 0;
      if (num < 27500 * longint'(vnr) * vno || num > 2200000 * longint'(vnr) * vno) return 0;
      return 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; cnt = 0; m_mode = 0; m_rst = 0; m_busy = 0; m_done = 0; m_err = 0;
         m_ref = 0; m_fb = 0; m_out = 0; m_bw = 0;
      end else begin
         m_done = 0; m_err = 0;
         if (ph == 0) begin
            if (start) begin
               if (req_ok(int'(nr), int'(nf), int'(no))) begin
                  m_mode = 0; m_busy = 1; l_nr = nr; l_nf = nf; l_no = no; ph = 1;
               end else m_err = 1;
            end
         end else if (ph == 1) begin
            m_rst = 1; ph = 2;
         end else if (ph == 2) begin
            m_ref = l_nr - 1; m_fb = l_nf - 1; m_out = l_no - 1; m_bw = (l_nf / 2) - 1;
            cnt = SETTLE; ph = 3;
         end else if (ph == 3) begin
            cnt--;
            if (cnt == 0) begin m_rst = 0; cnt = TMO; ph = 4; end
         end else begin
            if (lock) begin
               m_mode = 1; m_busy = 0; m_done = 1; ph = 0;
            end else begin
               cnt--;
               if (cnt == 0) begin m_busy = 0; m_err = 1; ph = 0; end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (model_on) begin
         chk(mode == m_mode[1:0], "R2/R6", "mode", mode, m_mode);
         chk(prst == m_rst, "R3/R5", "pll reset", prst, m_rst);
         chk(refdiv == m_ref[5:0], "R4", "ref field", refdiv, m_ref);
         chk(fbdiv == m_fb[12:0], "R4", "fb field", fbdiv, m_fb);
         chk(outdiv == m_out[3:0], "R4", "out field", outdiv, m_out);
         chk(bwadj == m_bw[11:0], "R4", "bw field", bwadj, m_bw);
         chk(busy == m_busy, "R2/R9", "busy", busy, m_busy);
         chk(done == m_done, "R6", "done", done, m_done);
         chk(err == m_err, "R7/R8/R10", "err", err, m_err);
      end
   end

   // lock model: rises LOCK_DLY cycles after reset release
   bit lock_en = 1;
   int lock_cnt = 0;
   always @(negedge clk) begin
      if (prst || !lock_en) begin
         lock_cnt = 0; lock = 1'b0;
      end else begin
         lock_cnt++;
         if (lock_cnt >= LOCK_DLY) lock = 1'b1;
      end
   end

   task automatic run(input int vnr, input int vnf, input int vno, input bit lk,
                      input int kind, input string req, input bit poke);
      int nd, ne;
      nd = 0; ne = 0;
      lock_en = lk;
      @(negedge clk);
      start = 1'b1; nr = 7'(vnr); nf = 14'(vnf); no = 5'(vno);
      @(negedge clk);
      start = 1'b0;
      if (done) nd++;
      if (err) ne++;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (done) nd++;
         if (err) ne++;
         if (poke && i == 5) begin
            start = 1'b1; nr = 7'd1; nf = 14'd75; no = 5'd1;
         end else start = 1'b0;
      end
      chk(nd == (kind == 0 ? 1 : 0), req, "done pulses", nd, kind == 0 ? 1 : 0);
      chk(ne == (kind == 0 ? 0 : 1), req, "error pulses", ne, kind == 0 ? 0 : 1);
      chk(busy == 1'b0, req, "busy after run", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(mode == 2'b00, "R1", "mode", mode, 0);
      chk(!prst && !busy && !done && !err, "R1", "controls", {prst, busy, done, err}, 0);
      chk(refdiv == 0 && fbdiv == 0 && outdiv == 0 && bwadj == 0, "R1", "fields", fbdiv, 0);
      rst_n = 1'b1;
      @(negedge clk);
      model_on = 1;

      run(1, 75, 1, 1, 0, "R4", 0);
      chk(fbdiv == 74 && bwadj == 36 && refdiv == 0 && outdiv == 0, "R4", "fields 1/75/1", fbdiv, 74);
      chk(mode == 2'b01, "R6", "mode normal", mode, 1);
      run(1, 50, 3, 1, 1, "R7", 0);
      chk(mode == 2'b01 && fbdiv == 74, "R7", "reject leaves state", fbdiv, 74);
      run(2, 50, 2, 1, 0, "R6", 0);
      chk(refdiv == 1 && fbdiv == 49 && outdiv == 1 && bwadj == 24, "R4", "fields 2/50/2", bwadj, 24);
      run(1, 18, 1, 1, 1, "R8", 0);
      run(3, 55, 16, 1, 0, "R8", 0);
      chk(refdiv == 2 && fbdiv == 54 && outdiv == 15 && bwadj == 26, "R8", "boundary 440/27.5", outdiv, 15);
      run(1, 92, 1, 1, 1, "R8", 0);
      run(1, 91, 1, 1, 0, "R8", 0);
      run(2, 50, 2, 1, 0, "R9", 1);
      chk(fbdiv == 49 && refdiv == 1, "R9", "start while busy ignored", fbdiv, 49);
      run(1, 75, 2, 0, 2, "R10", 0);
      chk(mode == 2'b00 && !prst, "R10", "timeout leaves slow", mode, 0);
      run(1, 75, 1, 1, 0, "R5", 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule